// File: doc/BRIEF.md
# Multichannel PWM Generator with Shadowed Edge Registers

This block drives up to sixteen PWM outputs from one shared period counter. A prescaler divides the clock into counting ticks. The period counter steps once per tick and wraps back to zero after it reaches the programmed period. Each channel has two edge registers, a rise position and a fall position. The channel output is high while the counter lies in the half-open window between those two positions.

A build-time mask chooses which channels get a second, pending copy of their two edge registers. On those channels a run-time mode bit selects how a write is applied. In period-aligned mode, a write lands in the pending copy and becomes active when the next period begins. In immediate mode, a write becomes active on the next clock, and a glitch inside the current period is accepted. Channels built without the pending copy always take writes immediately.

All registers are reached through a plain APB-style port with no wait states. A write is accepted in the access phase. Read data is a combinational function of the address.

Top module: `pwm_bank`

## Requirements
- R1: The prescaler counts clocks from 0. When its count reaches the prescale register value, it issues a tick and restarts at 0, so the period counter advances once every prescale+1 clocks and holds its value between ticks.
- R2: On a tick, a period counter at or above the period register value goes to 0 instead of incrementing. That tick is the period-start event. A period value written below the current count therefore causes a wrap on the next tick.
- R3: Output bit i is 1 exactly when counter >= rise_i and counter < fall_i. It is 0 when rise_i equals fall_i and when rise_i is greater than fall_i.
- R4: On a channel with a pending copy whose mode bit is 1, a write to an edge register updates only the pending copy. A read returns the pending value, and the active value takes the pending value at the period-start event.
- R5: On a channel with a pending copy whose mode bit is 0, a write makes the active value equal the written value on the next clock. This holds even when the write coincides with a period-start event.
- R6: On channels built without a pending copy, the mode bit is ignored and every edge write is immediate. The mode bits of those channels, and of channels above the implemented count, always read 0.
- R7: After reset, prescale, period, all edge registers and all mode bits are 0, and every output is 0.
- R8: Word address map: 0 holds the prescale value, 1 holds the period value, 2+2*i holds the rise of channel i, 3+2*i holds the fall of channel i, and 34 holds the mode bits (bit i for channel i). Addresses of channels that are not implemented, and any other address, read 0 and ignore writes.
- R9: A channel with a pending copy copies its pending edges into its active edges at every period-start event in either mode. A pending value left over from period-aligned mode therefore goes live at the next period start after a switch to immediate mode.
- R10: A register changes only on a clock where psel, penable and pwrite are all 1. A setup phase with penable at 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW | Word address |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data for paddr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench aims writes at period-aligned channels in the middle of a period. A design that let such a write through early would show the new edge before the wrap. Immediate writes are fired densely with a short period, so that some of them land on the exact period-start clock; a design with the wrong priority there would keep the stale pending value for one period. The bench also leaves a pending edge behind, switches the channel to immediate mode, and then shrinks the period below the running count. A design missing either the every-period copy or the at-or-above wrap would miss the leftover edge or count through the whole counter range. Further cases cover equal and reversed edges, mode bits on channels built without a pending copy, unimplemented addresses, and setup-only transfers, each of which a faulty design would turn into a stray output level or a nonzero read.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int MAX_CH     = 16;
  localparam int A_PRESCALE = 0;
  localparam int A_PERIOD   = 1;
  localparam int A_CH_BASE  = 2;
  localparam int A_SYNC     = A_CH_BASE + 2 * MAX_CH;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_we_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          pstart
);
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick   = (pre_q >= prescale);
  assign pstart = tick && (cnt_q >= period);
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= (cnt_q >= period) ? '0 : cnt_q + 1'b1;
    end
  end

  // R1: the counter only moves on a tick
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R2: a period start always lands the counter on zero
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pstart |=> (cnt_q == '0));
  // R1: a tick without a wrap increments the counter by one
  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pstart) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CW         = 16,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          pstart,
  input  logic          sync_en,
  input  edge_we_t      we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_rise,
  output logic [CW-1:0] rd_fall,
  output logic          pwm
);
  logic [CW-1:0] act_rise, act_fall;

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [CW-1:0] pend_rise, pend_fall;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_rise <= '0;
          pend_fall <= '0;
        end else begin
          if (we.rise) pend_rise <= wdata;
          if (we.fall) pend_fall <= wdata;
        end
      end

      // an immediate write wins over the period-start copy
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_rise <= '0;
          act_fall <= '0;
        end else begin
          if (we.rise && !sync_en) act_rise <= wdata;
          else if (pstart)         act_rise <= pend_rise;
          if (we.fall && !sync_en) act_fall <= wdata;
          else if (pstart)         act_fall <= pend_fall;
        end
      end

      assign rd_rise = pend_rise;
      assign rd_fall = pend_fall;

      // R4: in period-aligned mode the active edges move only at a period start
      p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !pstart) |=> ($stable(act_rise) && $stable(act_fall)));
      // R4: a write is visible on read-back on the next clock
      p_pending_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we.rise |=> (rd_rise == $past(wdata)));
      // R5: an immediate-mode write is active on the next clock
      p_async_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we.fall && !sync_en) |=> (act_fall == $past(wdata)));
      // R9: a period start with no write copies pending into active
      p_copy_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart && !we.rise) |=> (act_rise == $past(pend_rise)));
    end else begin : g_direct
      logic unused_direct;
      assign unused_direct = sync_en ^ pstart;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_rise <= '0;
          act_fall <= '0;
        end else begin
          if (we.rise) act_rise <= wdata;
          if (we.fall) act_fall <= wdata;
        end
      end

      assign rd_rise = act_rise;
      assign rd_fall = act_fall;

      // R6: without a pending copy every write is immediate
      p_direct_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we.rise |=> (act_rise == $past(wdata)));
    end
  endgenerate

  assign pwm = (cnt >= act_rise) && (cnt < act_fall);
endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
  import pwm_bank_pkg::*;
#(
  parameter int              NCH         = 16,
  parameter int              CW          = 16,
  parameter int              PW          = 8,
  parameter int              AW          = 8,
  parameter int              DW          = 32,
  parameter logic [MAX_CH-1:0] SHADOW_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [AW-1:0]           paddr,
  input  logic [DW-1:0]           pwdata,
  output logic [DW-1:0]           prdata,
  output logic [PW-1:0]           prescale,
  output logic [CW-1:0]           period,
  output logic [NCH-1:0]          sync_en,
  output logic [NCH-1:0]          we_rise,
  output logic [NCH-1:0]          we_fall,
  output logic [CW-1:0]           wdata,
  input  logic [NCH-1:0][CW-1:0]  rd_rise,
  input  logic [NCH-1:0][CW-1:0]  rd_fall
);
  localparam logic [NCH-1:0] SYNC_MASK = SHADOW_MASK[NCH-1:0];

  logic          wr;
  logic [PW-1:0] prescale_q;
  logic [CW-1:0] period_q;
  logic [NCH-1:0] sync_q;
  logic          unused_hi;

  assign wr        = psel && penable && pwrite;
  assign wdata     = pwdata[CW-1:0];
  assign unused_hi = ^pwdata;
  assign prescale  = prescale_q;
  assign period    = period_q;
  assign sync_en   = sync_q;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_dec
      assign we_rise[g] = wr && (paddr == AW'(A_CH_BASE + 2 * g));
      assign we_fall[g] = wr && (paddr == AW'(A_CH_BASE + 2 * g + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescale_q <= '0;
      period_q   <= '0;
      sync_q     <= '0;
    end else if (wr) begin
      if (paddr == AW'(A_PRESCALE)) prescale_q <= pwdata[PW-1:0];
      if (paddr == AW'(A_PERIOD))   period_q   <= pwdata[CW-1:0];
      if (paddr == AW'(A_SYNC))     sync_q     <= pwdata[NCH-1:0] & SYNC_MASK;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == AW'(A_PRESCALE)) prdata[PW-1:0]  = prescale_q;
    if (paddr == AW'(A_PERIOD))   prdata[CW-1:0]  = period_q;
    if (paddr == AW'(A_SYNC))     prdata[NCH-1:0] = sync_q;
    for (int i = 0; i < NCH; i++) begin
      if (paddr == AW'(A_CH_BASE + 2 * i))     prdata[CW-1:0] = rd_rise[i];
      if (paddr == AW'(A_CH_BASE + 2 * i + 1)) prdata[CW-1:0] = rd_fall[i];
    end
  end

  // R10: configuration is untouched without a full write access
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> ($stable(period_q) && $stable(prescale_q) && $stable(sync_q)));
  // R6: mode bits of channels without a pending copy never become set
  p_sync_unbuilt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == AW'(A_SYNC)) |=> ((sync_en & ~SYNC_MASK) == '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int              NCH         = 16,
  parameter int              CW          = 16,
  parameter int              PW          = 8,
  parameter int              AW          = 8,
  parameter int              DW          = 32,
  parameter logic [MAX_CH-1:0] SHADOW_MASK = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic [NCH-1:0] pwm_out
);
  logic [PW-1:0]          prescale;
  logic [CW-1:0]          period;
  logic [CW-1:0]          cnt;
  logic                   pstart;
  logic [NCH-1:0]         sync_en;
  logic [NCH-1:0]         we_rise, we_fall;
  logic [CW-1:0]          wdata;
  logic [NCH-1:0][CW-1:0] rd_rise, rd_fall;

  pwm_timebase #(.CW(CW), .PW(PW)) u_tb (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .period(period),
    .cnt(cnt), .pstart(pstart)
  );

  pwm_regif #(
    .NCH(NCH), .CW(CW), .PW(PW), .AW(AW), .DW(DW), .SHADOW_MASK(SHADOW_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .prescale(prescale),
    .period(period), .sync_en(sync_en), .we_rise(we_rise), .we_fall(we_fall),
    .wdata(wdata), .rd_rise(rd_rise), .rd_fall(rd_fall)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      edge_we_t we_g;
      assign we_g.rise = we_rise[g];
      assign we_g.fall = we_fall[g];

      pwm_chan #(.CW(CW), .HAS_SHADOW(SHADOW_MASK[g])) u_ch (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .pstart(pstart),
        .sync_en(sync_en[g]), .we(we_g), .wdata(wdata),
        .rd_rise(rd_rise[g]), .rd_fall(rd_fall[g]), .pwm(pwm_out[g])
      );
    end
  endgenerate

  // R7: all outputs are low on the first clock after reset
  p_reset_low_r7: assert property (@(posedge clk)
    !rst_n |=> (pwm_out == '0));
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NCH = 6, CW = 16, PW = 8, AW = 8, DW = 32;
  localparam logic [15:0] SHM = 16'h0035;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic [NCH-1:0] pwm_out;

  always #4 clk = ~clk;

  pwm_bank #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW), .DW(DW), .SHADOW_MASK(SHM)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwm_out(pwm_out)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  string cur_req = "R7";

  // behavioural reference state
  int m_pre, m_cnt, m_ps, m_per, m_sync;
  int ar[NCH], af[NCH], pr[NCH], pf[NCH];

  function automatic int m_read(int a);
    if (a == 0) return m_ps;
    if (a == 1) return m_per;
    if (a == 34) return m_sync;
    for (int i = 0; i < NCH; i++) begin
      if (a == 2 + 2 * i) return pr[i];
      if (a == 3 + 2 * i) return pf[i];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ps = 0; m_per = 0; m_sync = 0;
      for (int i = 0; i < NCH; i++) begin ar[i] = 0; af[i] = 0; pr[i] = 0; pf[i] = 0; end
    end else begin
      bit tk, ps, wr;
      int a, v, old_sync;
      wr = psel && penable && pwrite;
      a = int'(paddr);
      v = int'(pwdata[CW-1:0]);
      tk = (m_pre >= m_ps);
      ps = tk && (m_cnt >= m_per);
      old_sync = m_sync;
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_cnt = ps ? 0 : m_cnt + 1;
      for (int i = 0; i < NCH; i++) begin
        if (SHM[i] && ps) begin ar[i] = pr[i]; af[i] = pf[i]; end
      end
      if (wr) begin
        if (a == 0) m_ps = int'(pwdata[PW-1:0]);
        if (a == 1) m_per = v;
        if (a == 34) m_sync = int'(pwdata[NCH-1:0]) & int'(SHM[NCH-1:0]);
        for (int i = 0; i < NCH; i++) begin
          bit imm;
          imm = !SHM[i] || !old_sync[i];
          if (a == 2 + 2 * i) begin pr[i] = v; if (imm) ar[i] = v; end
          if (a == 3 + 2 * i) begin pf[i] = v; if (imm) af[i] = v; end
        end
      end
    end
  end

  // compare outputs against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) e[i] = (m_cnt >= ar[i]) && (m_cnt < af[i]);
      total++;
      if (pwm_out !== e) begin
        bad++;
        $display("FAIL %s cnt=%0d pwm_out=%h expected=%h", cur_req, m_cnt, pwm_out, e);
      end
    end
  end

  task automatic check_val(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = AW'(a); pwdata = DW'(d);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = AW'(a);
    #1;
    check_val(req, prdata, DW'(m_read(a)));
    @(negedge clk);
    psel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_val("R7", DW'(pwm_out), '0);
    rd(0, "R7"); rd(1, "R7"); rd(34, "R7"); rd(2, "R7");

    // R1 R3: prescale 2, period 9, assorted edge patterns
    cur_req = "R1";
    wr(0, 2); wr(1, 9);
    wr(2, 2); wr(3, 6);     // ch0 normal window
    wr(4, 0); wr(5, 5);     // ch1 starts at zero
    wr(6, 7); wr(7, 3);     // ch2 reversed edges, low (R3)
    wr(8, 4); wr(9, 4);     // ch3 equal edges, low (R3)
    wr(10, 1); wr(11, 9);   // ch4 to the end
    wr(12, 3); wr(13, 8);   // ch5
    cur_req = "R3";
    idle(60);
    rd(2, "R3"); rd(7, "R3");

    // R6: mode bits only stick on channels with a pending copy
    cur_req = "R6";
    wr(34, 16'hFFFF);
    rd(34, "R6");
    wr(5, 2);               // ch1 no pending copy: immediate
    idle(10);

    // R4: mid-period writes in period-aligned mode
    cur_req = "R4";
    wr(2, 5); rd(2, "R4");
    wr(11, 4); rd(11, "R4");
    idle(50);

    // R9: leave a pending value, then switch to immediate mode
    cur_req = "R9";
    wr(3, 8);
    wr(34, 0);
    rd(3, "R9");
    idle(40);

    // R5: dense immediate writes with frequent period starts
    cur_req = "R5";
    wr(0, 0); wr(1, 3);
    for (int k = 0; k < 16; k++) begin
      wr(10, k % 4);
      wr(11, (k % 5) + 1);
    end
    idle(20);

    // R2: shrink the period below the running count
    cur_req = "R2";
    wr(1, 40);
    while (m_cnt <= 20) @(negedge clk);
    wr(1, 6);
    idle(30);
    rd(1, "R2");

    // R8: unmapped and unimplemented addresses
    cur_req = "R8";
    rd(16, "R8");
    wr(16, 123);
    rd(16, "R8");
    rd(14, "R8");
    wr(40, 5);
    rd(40, "R8");
    rd(34, "R8");

    // R10: a setup phase alone writes nothing
    cur_req = "R10";
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = AW'(1); pwdata = 77;
    idle(2);
    psel = 1'b0; pwrite = 1'b0;
    rd(1, "R10");
    idle(5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule